// File: doc/BRIEF.md
# Interrupt Routing Configuration Register File

This block holds the configuration of an interrupt routing unit behind a two-location window on a 32-bit bus. Software first writes an index into the select location, then reads or writes the data location, which reaches whichever internal register that index names. Behind the window sit a 4-bit unit identifier, a fixed version word, an arbitration word that always reads zero, and a table of per-pin routing entries. Each entry is 64 bits wide and occupies two consecutive indices.

The decoded fields of every entry are driven out in parallel to the delivery logic. Each time software writes either half of an entry, the block raises a one-cycle service request so that the delivery logic rescans the table. Two status bits of each entry, busy and remote-accepted, belong to the delivery logic. The block shows them on reads but never stores them.

Top module: `irq_route_regfile`

## Requirements
- R1: `bus_ofs` 0x00 is the select register, which stores all 32 written bits and reads them back unchanged. `bus_ofs` 0x10 is the data window. Only the low 8 bits of the select value choose the internal register.
- R2: At index 0x00 the unit ID reads back in bits 27:24, with every other bit zero. A window write at this index loads the ID from bits 27:24 of the write data.
- R3: Index 0x01 reads the version word 0x00170011 when there are 24 pins: the highest entry number is in bits 23:16 and the revision 0x11 is in bits 7:0. Window writes to it change nothing.
- R4: Index 0x02 always reads 0, and window writes to it change nothing.
- R5: Index 0x10+2n reaches the low half of entry n and index 0x11+2n reaches its high half. The low half holds vector[7:0], delivery mode[10:8], destination mode[11], busy[12], polarity[13], remote-accepted[14], level-trigger[15] and mask[16]. The high half holds the destination in bits 31:24. All other bits read 0.
- R6: After reset the select register and the ID are 0. Every entry's low half reads 0x00010000 (masked) and its high half reads 0.
- R7: A write to either half of an entry raises `svc_req` for exactly one cycle, in the cycle after the write. Writes to any other register leave it low.
- R8: Bits 12 and 14 of an entry's low half read the live `dlv_busy_in` and `dlv_rirr_in` bits of that pin. Bus writes to those two bits store nothing.
- R9: The `pin_*` outputs show the stored fields of every entry, and they update in the cycle after the write.
- R10: Any access to an offset other than 0x00 or 0x10, or a window access at an undefined index, raises `bus_err` for one cycle. Such a read returns 0 and such a write changes no register.
- R11: Read data appears on `bus_rdata` in the cycle after the `bus_rd` strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ofs | input | 8 | Low address bits of the access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for an undefined access |
| dlv_busy_in | input | NPINS | Per-pin busy status from delivery logic |
| dlv_rirr_in | input | NPINS | Per-pin remote-accepted status from delivery logic |
| svc_req | output | 1 | One-cycle pulse after any entry write |
| pin_vector | output | NPINS*8 | Vector of each pin |
| pin_dmode | output | NPINS*3 | Delivery mode of each pin |
| pin_destmode | output | NPINS | Destination mode of each pin |
| pin_polarity | output | NPINS | Input polarity of each pin |
| pin_level | output | NPINS | Level-triggered flag of each pin |
| pin_mask | output | NPINS | Mask of each pin |
| pin_dest | output | NPINS*8 | Destination of each pin |

## Verification
Every result of the block is due one clock edge after the strobe that causes it: the read data, the error pulse, the service pulse and the updated `pin_*` fields. The bench drives a strobe on a falling edge and removes it on the next falling edge. It samples all outputs at that same falling edge, which comes half a period after the capturing rising edge. It then waits one more cycle to confirm that each pulse has fallen and that read data has held.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] IDX_UNIT   = 8'h00;
  localparam logic [7:0] IDX_REV    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;
  localparam logic [7:0] IDX_TABLE  = 8'h10;

  // stored fields of one routing entry
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       polarity;
    logic       destmode;
    logic [2:0] dmode;
    logic [7:0] vector;
  } rte_t;

  // bus view of an entry: {high half, low half}
  function automatic logic [63:0] entry_words(rte_t e, logic busy, logic rirr);
    return {e.dest, 24'h0,
            15'h0, e.mask, e.level, rirr, e.polarity, busy,
            e.destmode, e.dmode, e.vector};
  endfunction

  function automatic logic [31:0] rev_word(int unsigned npins, logic [7:0] rev);
    return {8'h00, 8'(npins - 1), 8'h00, rev};
  endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  localparam int unsigned IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [7:0]    ofs,
  input  logic [7:0]    sel,
  output logic          hit_sel,
  output logic          hit_unit,
  output logic          hit_rev,
  output logic          hit_arb,
  output logic          hit_ent,
  output logic          ent_hi,
  output logic [IW-1:0] ent_idx,
  output logic          bad
);
  localparam logic [7:0] TBL_SPAN = 8'(2 * NPINS);

  logic       win;
  logic [7:0] rel;
  logic       in_tbl;

  always_comb begin
    win      = (ofs == OFS_WINDOW);
    rel      = sel - IDX_TABLE;
    in_tbl   = (sel >= IDX_TABLE) && (rel < TBL_SPAN);
    hit_sel  = (ofs == OFS_SELECT);
    hit_unit = win && (sel == IDX_UNIT);
    hit_rev  = win && (sel == IDX_REV);
    hit_arb  = win && (sel == IDX_ARB);
    hit_ent  = win && in_tbl;
    ent_hi   = rel[0];
    ent_idx  = rel[IW:1];
    bad      = !(hit_sel || hit_unit || hit_rev || hit_arb || hit_ent);
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  rte_t        wr_cfg,
  input  logic        busy_in,
  input  logic        rirr_in,
  output rte_t        cfg,
  output logic [63:0] words
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      cfg.mask <= 1'b1;
    end else begin
      if (wr_lo) begin
        cfg.vector   <= wr_cfg.vector;
        cfg.dmode    <= wr_cfg.dmode;
        cfg.destmode <= wr_cfg.destmode;
        cfg.polarity <= wr_cfg.polarity;
        cfg.level    <= wr_cfg.level;
        cfg.mask     <= wr_cfg.mask;
      end
      if (wr_hi) cfg.dest <= wr_cfg.dest;
    end
  end

  assign words = entry_words(cfg, busy_in, rirr_in);

  // R5: an entry keeps its contents unless one of its halves is written
  a_r5_entry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> $stable(cfg));
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter logic [7:0]  REV     = 8'h11,
  parameter logic [3:0]  UNIT_ID = 4'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         bus_ofs,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  input  logic [NPINS-1:0]   dlv_busy_in,
  input  logic [NPINS-1:0]   dlv_rirr_in,
  output logic               svc_req,
  output logic [NPINS*8-1:0] pin_vector,
  output logic [NPINS*3-1:0] pin_dmode,
  output logic [NPINS-1:0]   pin_destmode,
  output logic [NPINS-1:0]   pin_polarity,
  output logic [NPINS-1:0]   pin_level,
  output logic [NPINS-1:0]   pin_mask,
  output logic [NPINS*8-1:0] pin_dest
);
  localparam int unsigned IW       = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [31:0] REV_WORD = rev_word(NPINS, REV);

  logic [31:0]   sel_q;
  logic [3:0]    unit_q;
  logic          hit_sel, hit_unit, hit_rev, hit_arb, hit_ent, ent_hi, bad;
  logic [IW-1:0] ent_idx;
  logic [31:0]   rd_mux;
  rte_t          wr_cfg;
  rte_t          cfg   [NPINS];
  logic [63:0]   words [NPINS];

  irq_route_decode #(.NPINS(NPINS)) dec_i (
    .ofs(bus_ofs), .sel(sel_q[7:0]),
    .hit_sel(hit_sel), .hit_unit(hit_unit), .hit_rev(hit_rev),
    .hit_arb(hit_arb), .hit_ent(hit_ent), .ent_hi(ent_hi),
    .ent_idx(ent_idx), .bad(bad)
  );

  always_comb begin
    wr_cfg.vector   = bus_wdata[7:0];
    wr_cfg.dmode    = bus_wdata[10:8];
    wr_cfg.destmode = bus_wdata[11];
    wr_cfg.polarity = bus_wdata[13];
    wr_cfg.level    = bus_wdata[15];
    wr_cfg.mask     = bus_wdata[16];
    wr_cfg.dest     = bus_wdata[31:24];
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic sel_me;
    assign sel_me = bus_wr && hit_ent && (ent_idx == IW'(i));
    irq_route_entry ent_i (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(sel_me && !ent_hi), .wr_hi(sel_me && ent_hi),
      .wr_cfg(wr_cfg), .busy_in(dlv_busy_in[i]), .rirr_in(dlv_rirr_in[i]),
      .cfg(cfg[i]), .words(words[i])
    );
    assign pin_vector[i*8 +: 8] = cfg[i].vector;
    assign pin_dmode[i*3 +: 3]  = cfg[i].dmode;
    assign pin_destmode[i]      = cfg[i].destmode;
    assign pin_polarity[i]      = cfg[i].polarity;
    assign pin_level[i]         = cfg[i].level;
    assign pin_mask[i]          = cfg[i].mask;
    assign pin_dest[i*8 +: 8]   = cfg[i].dest;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_sel)       rd_mux = sel_q;
    else if (hit_unit) rd_mux = {4'h0, unit_q, 24'h0};
    else if (hit_rev)  rd_mux = REV_WORD;
    else if (hit_ent)  rd_mux = ent_hi ? words[ent_idx][63:32] : words[ent_idx][31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      unit_q    <= UNIT_ID;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      svc_req   <= 1'b0;
    end else begin
      bus_err <= (bus_rd || bus_wr) && bad;
      svc_req <= bus_wr && hit_ent;
      if (bus_rd)              bus_rdata <= rd_mux;
      if (bus_wr && hit_sel)   sel_q     <= bus_wdata;
      if (bus_wr && hit_unit)  unit_q    <= bus_wdata[27:24];
    end
  end

  // R7: a service request only ever follows a bus write
  a_r7_svc_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(bus_wr));
  // R7 / R10: a service request and an error never coincide
  a_r7_svc_not_err: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> !bus_err);
  // R10: an error pulse only follows an access
  a_r10_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd || bus_wr));
  // R10: a failed read returns zero
  a_r10_err_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && $past(bus_rd)) |-> (bus_rdata == 32'h0));
  // R1: at most one target is decoded for any access
  a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_sel, hit_unit, hit_rev, hit_arb, hit_ent}));
  // R11: read data moves only after a read strobe
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_route_regfile_tb_top.sv
`timescale 1ns/1ps
module irq_route_regfile_tb_top;
  localparam int unsigned NP = 24;
  localparam realtime     PERIOD = 8.0;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     bus_ofs = '0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           bus_err, svc_req;
  logic [NP-1:0]  dlv_busy_in = '0, dlv_rirr_in = '0;
  logic [NP*8-1:0] pin_vector, pin_dest;
  logic [NP*3-1:0] pin_dmode;
  logic [NP-1:0]  pin_destmode, pin_polarity, pin_level, pin_mask;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irq_route_regfile #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .dlv_busy_in(dlv_busy_in), .dlv_rirr_in(dlv_rirr_in), .svc_req(svc_req),
    .pin_vector(pin_vector), .pin_dmode(pin_dmode), .pin_destmode(pin_destmode),
    .pin_polarity(pin_polarity), .pin_level(pin_level), .pin_mask(pin_mask),
    .pin_dest(pin_dest)
  );

  // {is_write, offset, wdata, expected rdata, expected err, expected svc}
  localparam int NV = 35;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,        32'h0,        1'b0, 1'b0}, // R6 select reset
    {1'b0, 8'h10, 32'h0,        32'h0,        1'b0, 1'b0}, // R6 unit id reset
    {1'b1, 8'h10, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0}, // R2 load id
    {1'b0, 8'h10, 32'h0,        32'h0F000000, 1'b0, 1'b0}, // R2 id readback
    {1'b1, 8'h00, 32'h00000001, 32'h0,        1'b0, 1'b0},
    {1'b0, 8'h00, 32'h0,        32'h00000001, 1'b0, 1'b0}, // R1 select readback
    {1'b0, 8'h10, 32'h0,        32'h00170011, 1'b0, 1'b0}, // R3 version
    {1'b1, 8'h10, 32'hDEADBEEF, 32'h0,        1'b0, 1'b0}, // R3 write ignored
    {1'b0, 8'h10, 32'h0,        32'h00170011, 1'b0, 1'b0}, // R3
    {1'b1, 8'h00, 32'h00000002, 32'h0,        1'b0, 1'b0},
    {1'b1, 8'h10, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0}, // R4 write ignored
    {1'b0, 8'h10, 32'h0,        32'h0,        1'b0, 1'b0}, // R4 reads zero
    {1'b1, 8'h00, 32'h00000010, 32'h0,        1'b0, 1'b0},
    {1'b0, 8'h10, 32'h0,        32'h00010000, 1'b0, 1'b0}, // R6 entry 0 low
    {1'b1, 8'h10, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b1}, // R7 pulse
    {1'b0, 8'h10, 32'h0,        32'h0001AFFF, 1'b0, 1'b0}, // R5 R8 stored bits
    {1'b1, 8'h00, 32'h00000011, 32'h0,        1'b0, 1'b0},
    {1'b0, 8'h10, 32'h0,        32'h0,        1'b0, 1'b0}, // R6 entry 0 high
    {1'b1, 8'h10, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b1}, // R7
    {1'b0, 8'h10, 32'h0,        32'hFF000000, 1'b0, 1'b0}, // R5 high field
    {1'b1, 8'h00, 32'h0000003F, 32'h0,        1'b0, 1'b0},
    {1'b0, 8'h10, 32'h0,        32'h0,        1'b0, 1'b0}, // R6 last entry high
    {1'b1, 8'h00, 32'h0000003E, 32'h0,        1'b0, 1'b0},
    {1'b0, 8'h10, 32'h0,        32'h00010000, 1'b0, 1'b0}, // R6 last entry low
    {1'b1, 8'h00, 32'hABCD0140, 32'h0,        1'b0, 1'b0},
    {1'b0, 8'h00, 32'h0,        32'hABCD0140, 1'b0, 1'b0}, // R1 full 32 bits
    {1'b0, 8'h10, 32'h0,        32'h0,        1'b1, 1'b0}, // R10 index 0x40
    {1'b1, 8'h10, 32'h00000123, 32'h0,        1'b1, 1'b0}, // R10
    {1'b1, 8'h00, 32'h00000003, 32'h0,        1'b0, 1'b0},
    {1'b0, 8'h10, 32'h0,        32'h0,        1'b1, 1'b0}, // R10 index 3
    {1'b0, 8'h04, 32'h0,        32'h0,        1'b1, 1'b0}, // R10 bad offset
    {1'b1, 8'h20, 32'hFFFFFFFF, 32'h0,        1'b1, 1'b0}, // R10 bad offset write
    {1'b0, 8'h00, 32'h0,        32'h00000003, 1'b0, 1'b0}, // R10 select untouched
    {1'b1, 8'h00, 32'h00000000, 32'h0,        1'b0, 1'b0},
    {1'b0, 8'h10, 32'h0,        32'h0F000000, 1'b0, 1'b0}  // R10 id untouched
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // strobe on a falling edge; results are sampled at the next falling edge
  task automatic access(input bit wr, input logic [7:0] ofs, input logic [31:0] wd);
    @(negedge clk);
    bus_ofs = ofs; bus_wdata = wd; bus_wr = wr; bus_rd = !wr;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state at the ports
    check(pin_mask == '1, "R6", 32'(pin_mask), 32'(24'hFFFFFF));
    check(!svc_req && !bus_err, "R6", {30'h0, svc_req, bus_err}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [74:0] v;
      v = VEC[k];
      access(v[74], v[73:66], v[65:34]);
      if (!v[74]) check(bus_rdata == v[33:2], $sformatf("R11 vec %0d rdata", k), bus_rdata, v[33:2]);
      check(bus_err == v[1], $sformatf("R10 vec %0d err", k), 32'(bus_err), 32'(v[1]));
      check(svc_req == v[0], $sformatf("R7 vec %0d svc", k), 32'(svc_req), 32'(v[0]));
    end

    // R9: entry 5 low half, index 0x1A
    access(1'b1, 8'h00, 32'h0000001A);
    access(1'b1, 8'h10, 32'h0000AB42);
    check(svc_req, "R7", 32'(svc_req), 32'h1);
    @(negedge clk);
    check(!svc_req, "R7 one cycle", 32'(svc_req), 32'h0);
    check(pin_vector[5*8 +: 8] == 8'h42, "R9 vector", 32'(pin_vector[5*8 +: 8]), 32'h42);
    check(pin_dmode[5*3 +: 3] == 3'd3, "R9 dmode", 32'(pin_dmode[5*3 +: 3]), 32'h3);
    check(pin_destmode[5] && pin_polarity[5] && pin_level[5] && !pin_mask[5], "R9 flags",
          {28'h0, pin_destmode[5], pin_polarity[5], pin_level[5], pin_mask[5]}, 32'hE);
    check(pin_mask[4] && pin_mask[6], "R9 neighbours masked", {30'h0, pin_mask[4], pin_mask[6]}, 32'h3);
    access(1'b1, 8'h00, 32'h0000001B);
    access(1'b1, 8'h10, 32'h5A000000);
    check(pin_dest[5*8 +: 8] == 8'h5A, "R9 dest", 32'(pin_dest[5*8 +: 8]), 32'h5A);

    // R8: live status bits on the low half of entry 5
    dlv_busy_in[5] = 1'b1; dlv_rirr_in[5] = 1'b1;
    access(1'b1, 8'h00, 32'h0000001A);
    access(1'b0, 8'h10, 32'h0);
    check(bus_rdata == 32'h0000FB42, "R8 live status", bus_rdata, 32'h0000FB42);
    dlv_busy_in[5] = 1'b0; dlv_rirr_in[5] = 1'b0;
    access(1'b1, 8'h10, 32'h0000FFFF);
    access(1'b0, 8'h10, 32'h0);
    check(bus_rdata == 32'h0000AFFF, "R8 not stored", bus_rdata, 32'h0000AFFF);

    // R11: read data holds across a later write
    access(1'b1, 8'h00, 32'h00000001);
    check(bus_rdata == 32'h0000AFFF, "R11 hold", bus_rdata, 32'h0000AFFF);
    check(!svc_req, "R7 select write no pulse", 32'(svc_req), 32'h0);

    finish_run();
  end
endmodule